// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt inputs, latches a rising edge on each as a pending request, and raises a single request line toward a processor when an unmasked request outranks everything currently in service. Input 0 has the highest priority and input 7 the lowest. When the processor acknowledges, the block returns an 8-bit vector. The vector is formed from a programmed base and the number of the winning input. The block then records that input as in service until software retires it with a specific end-of-interrupt command. An automatic mode instead retires it during the acknowledge itself.

Software reaches the block through a byte-wide port with two addresses. At the command address, one code starts a three-word setup sequence, other codes pick which status register a later read returns, and a third family of codes retires one in-service level. The data address first takes the setup words and afterwards holds the interrupt mask. Two copies can be chained. A master marks in its link word the inputs that carry a subordinate unit. When one of those inputs wins an acknowledge, the master sends out that input's number on a cascade strobe and returns no vector itself. A unit set up as a subordinate ignores the acknowledge line. It answers only to a strobe that carries its own link number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request and in-service registers are zero, the mask is 0xFF, command-address reads return the request register, and `int_req` is low.
- R2: A command write with bit 4 set (e.g. 0x11) starts setup and clears the request and in-service registers. It also selects the request register for reads. The next three data writes load the vector base, the link word and the mode word, in that order, and they leave the mask unchanged.
- R3: Outside setup, a data write loads the mask, and a data read returns it unchanged. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R4: A rising edge on an input sets its request bit. The bit clears as soon as the input is seen low. `int_req` goes high, two cycles after the edge, while an unmasked request outranks every in-service level.
- R5: Priority is fixed with input 0 highest. A request is blocked while the in-service bit at its own level or at any higher-priority level is set.
- R6: On an acknowledge with a winner, the vector `{base[7:3], n}` is valid for one cycle, starting one cycle after `int_ack`. In the same step, request bit n clears and in-service bit n sets.
- R7: Command write 0x0B makes later command reads return the in-service register. Command write 0x0A makes them return the request register.
- R8: Command write 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R9: With mode word bit 1 set, an acknowledge leaves the in-service register unchanged.
- R10: An acknowledge with no eligible request returns the vector `{base[7:3], 3'd7}` and sets no in-service bit. This covers a request whose input dropped before the acknowledge, and a request that was masked before it.
- R11: In a master (mode word bit 2 clear), an acknowledge won by an input whose link-word bit is set produces no vector. Instead, one cycle later, `cas_stb_out` pulses with `cas_id_out` set to that input number.
- R12: In a subordinate (mode word bit 2 set), `int_ack` has no effect. A `cas_stb_in` pulse whose `cas_id_in` equals link word bits [2:0] acts as the acknowledge, and the vector follows one cycle later.
- R13: With the mask at 0xFF, `int_req` stays low whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Interrupt inputs, edge sensitive |
| int_req | output | 1 | Request toward the processor or the master |
| int_ack | input | 1 | One-cycle acknowledge pulse (master only) |
| vec_out | output | 8 | Vector, meaningful while `vec_valid` |
| vec_valid | output | 1 | One-cycle vector strobe |
| cas_id_in | input | 3 | Cascade number from a master |
| cas_stb_in | input | 1 | Cascade strobe from a master |
| cas_id_out | output | 3 | Cascade number toward subordinates |
| cas_stb_out | output | 1 | Cascade strobe toward subordinates |

## Verification
The assertions assume that the interrupt inputs are already synchronous to `clk`. They also assume that `int_ack` and `cas_stb_in` are single-cycle pulses. The link word and mode word must not change in the cycles around an acknowledge, and a setup or end-of-interrupt write must not land in the same cycle as one. The stimulus changes every input only at falling edges. It programs each unit completely before it raises any request, and it issues acknowledges and register writes from separate tasks, so no command ever coincides with an acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    CFG_READY,
    CFG_BASE,
    CFG_LINK,
    CFG_MODE
  } cfg_state_t;

  localparam int unsigned MODE_AUTO_BIT  = 1;
  localparam int unsigned MODE_SUB_BIT   = 2;
  localparam int unsigned CMD_SETUP_BIT  = 4;
  localparam int unsigned CMD_SEL_BIT    = 3;
  localparam logic [2:0]  CMD_EOI_CODE   = 3'b011;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int unsigned N_IN = 8,
  parameter int unsigned DW   = 8,
  localparam int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic                addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [N_IN-1:0]     mask_o,
  output logic [DW-IDX_W-1:0] base_o,
  output logic [N_IN-1:0]     link_o,
  output logic                auto_o,
  output logic                sub_o,
  output logic                rd_isr_o,
  output logic                setup_o,
  output logic                eoi_o,
  output logic [IDX_W-1:0]    eoi_lvl_o
);
  cfg_state_t              state_q;
  logic [N_IN-1:0]         mask_q;
  logic [DW-IDX_W-1:0]     base_q;
  logic [N_IN-1:0]         link_q;
  logic                    auto_q;
  logic                    sub_q;
  logic                    rd_isr_q;
  logic                    cmd_wr;
  logic                    dat_wr;

  assign cmd_wr = wr_i && !addr_i;
  assign dat_wr = wr_i && addr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CFG_READY;
      mask_q   <= '1;
      base_q   <= '0;
      link_q   <= '0;
      auto_q   <= 1'b0;
      sub_q    <= 1'b0;
      rd_isr_q <= 1'b0;
    end else if (cmd_wr) begin
      if (wdata_i[CMD_SETUP_BIT]) begin
        state_q  <= CFG_BASE;
        rd_isr_q <= 1'b0;
      end else if (wdata_i[CMD_SEL_BIT] && wdata_i[1]) begin
        rd_isr_q <= wdata_i[0];
      end
    end else if (dat_wr) begin
      unique case (state_q)
        CFG_BASE: begin
          base_q  <= wdata_i[DW-1:IDX_W];
          state_q <= CFG_LINK;
        end
        CFG_LINK: begin
          link_q  <= wdata_i[N_IN-1:0];
          state_q <= CFG_MODE;
        end
        CFG_MODE: begin
          auto_q  <= wdata_i[MODE_AUTO_BIT];
          sub_q   <= wdata_i[MODE_SUB_BIT];
          state_q <= CFG_READY;
        end
        default: mask_q <= wdata_i[N_IN-1:0];
      endcase
    end
  end

  always_comb begin
    setup_o   = cmd_wr && wdata_i[CMD_SETUP_BIT];
    eoi_o     = cmd_wr && !wdata_i[CMD_SETUP_BIT] && !wdata_i[CMD_SEL_BIT]
                && (wdata_i[7:5] == CMD_EOI_CODE);
    eoi_lvl_o = wdata_i[IDX_W-1:0];
  end

  assign mask_o   = mask_q;
  assign base_o   = base_q;
  assign link_o   = link_q;
  assign auto_o   = auto_q;
  assign sub_o    = sub_q;
  assign rd_isr_o = rd_isr_q;

  // R2: setup words never disturb the mask
  p_setup_keeps_mask_r2: assert property (@(posedge clk) disable iff (rst)
    dat_wr && (state_q != CFG_READY) |=> $stable(mask_q));

  // R2: the mode word closes the sequence
  p_setup_ends_r2: assert property (@(posedge clk) disable iff (rst)
    dat_wr && !cmd_wr && (state_q == CFG_MODE) |=> state_q == CFG_READY);
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] irq_i,
  input  logic            clr_all_i,
  input  logic [N_IN-1:0] ack_clr_i,
  output logic [N_IN-1:0] irr_o
);
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] irr_q;
  logic [N_IN-1:0] rise;

  assign rise = irq_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      if (clr_all_i) irr_q <= '0;
      else           irr_q <= (irr_q | rise) & irq_i & ~ack_clr_i;
    end
  end

  assign irr_o = irr_q;

  // R4: an input seen low leaves no pending request behind
  p_drop_clears_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irr_q & ~$past(irq_i)) == '0);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned N_IN = 8,
  localparam int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  irr_i,
  input  logic [N_IN-1:0]  mask_i,
  input  logic [N_IN-1:0]  isr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_IN-1:0] cand;
  logic            blk;

  assign cand = irr_i & ~mask_i;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    blk   = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (isr_i[i]) blk = 1'b1;
      if (!blk && !hit_o && cand[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_service.sv
module irqc_service #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned DW   = 8,
  localparam int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                setup_i,
  input  logic                ack_i,
  input  logic [IDX_W-1:0]    cas_sel_i,
  input  logic                cas_stb_i,
  input  logic                sub_i,
  input  logic                auto_i,
  input  logic [N_IN-1:0]     link_i,
  input  logic [DW-IDX_W-1:0] base_i,
  input  logic                hit_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                eoi_i,
  input  logic [IDX_W-1:0]    eoi_lvl_i,
  output logic [N_IN-1:0]     isr_o,
  output logic [N_IN-1:0]     ack_clr_o,
  output logic [DW-1:0]       vec_o,
  output logic                vec_vld_o,
  output logic [IDX_W-1:0]    cas_id_o,
  output logic                cas_stb_o
);
  logic [N_IN-1:0]  isr_q;
  logic [N_IN-1:0]  win_1h;
  logic [N_IN-1:0]  set_v;
  logic [N_IN-1:0]  eoi_v;
  logic             ack_go;
  logic             to_sub;
  logic [IDX_W-1:0] vec_low;

  always_comb begin
    ack_go    = sub_i ? (cas_stb_i && (cas_sel_i == link_i[IDX_W-1:0])) : ack_i;
    to_sub    = !sub_i && hit_i && link_i[idx_i];
    win_1h    = N_IN'(1) << idx_i;
    ack_clr_o = (ack_go && hit_i) ? win_1h : '0;
    set_v     = (ack_go && hit_i && !auto_i) ? win_1h : '0;
    eoi_v     = eoi_i ? (N_IN'(1) << eoi_lvl_i) : '0;
    vec_low   = hit_i ? idx_i : {IDX_W{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
      cas_id_o  <= '0;
      cas_stb_o <= 1'b0;
    end else begin
      if (setup_i) isr_q <= '0;
      else         isr_q <= (isr_q & ~eoi_v) | set_v;
      vec_vld_o <= ack_go && !to_sub;
      vec_o     <= {base_i, vec_low};
      cas_stb_o <= ack_go && to_sub;
      cas_id_o  <= idx_i;
    end
  end

  assign isr_o = isr_q;

  // R6: the winning level is recorded as in service
  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (rst)
    ack_go && hit_i && !auto_i && !setup_i |=> isr_q[$past(idx_i)]);

  // R8: a specific end-of-interrupt retires its level
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (rst)
    eoi_i && !ack_go && !setup_i |=> !isr_q[$past(eoi_lvl_i)]);

  // R9: automatic mode never records service
  p_auto_no_isr_r9: assert property (@(posedge clk) disable iff (rst)
    ack_go && auto_i && !eoi_i && !setup_i |=> isr_q == $past(isr_q));

  // R10: an empty acknowledge reports the lowest level and touches nothing
  p_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    ack_go && !hit_i && !eoi_i && !setup_i
    |=> vec_vld_o && (vec_o[IDX_W-1:0] == {IDX_W{1'b1}}) && (isr_q == $past(isr_q)));

  // R11: a cascade strobe only ever names a linked input of a master
  p_cas_target_r11: assert property (@(posedge clk) disable iff (rst)
    cas_stb_o |-> link_i[cas_id_o] && !sub_i && !vec_vld_o);

  // R12: a subordinate without a strobe never emits a vector
  p_sub_ignores_ack_r12: assert property (@(posedge clk) disable iff (rst)
    sub_i && !cas_stb_i && $stable(sub_i) |=> !vec_vld_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned DW   = 8,
  localparam int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_IN-1:0]  irq_in,
  output logic             int_req,
  input  logic             int_ack,
  output logic [DW-1:0]    vec_out,
  output logic             vec_valid,
  input  logic [IDX_W-1:0] cas_id_in,
  input  logic             cas_stb_in,
  output logic [IDX_W-1:0] cas_id_out,
  output logic             cas_stb_out
);
  logic [N_IN-1:0]     mask_w;
  logic [DW-IDX_W-1:0] base_w;
  logic [N_IN-1:0]     link_w;
  logic                auto_w;
  logic                sub_w;
  logic                rd_isr_w;
  logic                setup_w;
  logic                eoi_w;
  logic [IDX_W-1:0]    eoi_lvl_w;
  logic [N_IN-1:0]     irr_w;
  logic [N_IN-1:0]     isr_w;
  logic [N_IN-1:0]     ack_clr_w;
  logic                hit_w;
  logic [IDX_W-1:0]    idx_w;
  logic                int_req_q;
  logic [DW-1:0]       rdata_q;

  irqc_cfg #(.N_IN(N_IN), .DW(DW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .mask_o    (mask_w),
    .base_o    (base_w),
    .link_o    (link_w),
    .auto_o    (auto_w),
    .sub_o     (sub_w),
    .rd_isr_o  (rd_isr_w),
    .setup_o   (setup_w),
    .eoi_o     (eoi_w),
    .eoi_lvl_o (eoi_lvl_w)
  );

  irqc_edge #(.N_IN(N_IN)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .irq_i     (irq_in),
    .clr_all_i (setup_w),
    .ack_clr_i (ack_clr_w),
    .irr_o     (irr_w)
  );

  irqc_arbiter #(.N_IN(N_IN)) u_arb (
    .irr_i  (irr_w),
    .mask_i (mask_w),
    .isr_i  (isr_w),
    .hit_o  (hit_w),
    .idx_o  (idx_w)
  );

  irqc_service #(.N_IN(N_IN), .DW(DW)) u_svc (
    .clk       (clk),
    .rst       (rst),
    .setup_i   (setup_w),
    .ack_i     (int_ack),
    .cas_sel_i (cas_id_in),
    .cas_stb_i (cas_stb_in),
    .sub_i     (sub_w),
    .auto_i    (auto_w),
    .link_i    (link_w),
    .base_i    (base_w),
    .hit_i     (hit_w),
    .idx_i     (idx_w),
    .eoi_i     (eoi_w),
    .eoi_lvl_i (eoi_lvl_w),
    .isr_o     (isr_w),
    .ack_clr_o (ack_clr_w),
    .vec_o     (vec_out),
    .vec_vld_o (vec_valid),
    .cas_id_o  (cas_id_out),
    .cas_stb_o (cas_stb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      int_req_q <= hit_w && !setup_w;
      if (bus_rd) begin
        if (bus_addr)      rdata_q <= DW'(mask_w);
        else if (rd_isr_w) rdata_q <= DW'(isr_w);
        else               rdata_q <= DW'(irr_w);
      end
    end
  end

  assign int_req   = int_req_q;
  assign bus_rdata = rdata_q;

  // R13: a fully closed mask keeps the request line quiet
  p_mask_all_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_w) == '1) |-> !int_req_q);

  // R1: reset leaves the request line low
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !int_req_q);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] m_rdata, s_rdata;
  logic [7:0] m_irq = '0, s_irq = '0;
  logic       ack = 1'b0;
  logic       m_int, s_int;
  logic [7:0] m_vec, s_vec;
  logic       m_vv, s_vv;
  logic [2:0] m_cid, s_cid;
  logic       m_cstb, s_cstb;
  logic [7:0] m_irq_in;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  assign m_irq_in = {m_irq[7:3], s_int, m_irq[1:0]};

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(m_wr), .bus_rd(m_rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(m_rdata), .irq_in(m_irq_in), .int_req(m_int),
    .int_ack(ack), .vec_out(m_vec), .vec_valid(m_vv), .cas_id_in(3'd0),
    .cas_stb_in(1'b0), .cas_id_out(m_cid), .cas_stb_out(m_cstb)
  );

  prio_irq_ctrl u_prio_irq_ctrl_sub (
    .clk(clk), .rst(rst), .bus_wr(s_wr), .bus_rd(s_rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(s_rdata), .irq_in(s_irq), .int_req(s_int),
    .int_ack(ack), .vec_out(s_vec), .vec_valid(s_vv), .cas_id_in(m_cid),
    .cas_stb_in(m_cstb), .cas_id_out(s_cid), .cas_stb_out(s_cstb)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input bit sub, input bit a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sub) s_wr = 1'b1; else m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0; s_wr = 1'b0;
  endtask

  task automatic bus_read(input bit sub, input bit a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    if (sub) s_rd = 1'b1; else m_rd = 1'b1;
    @(negedge clk);
    m_rd = 1'b0; s_rd = 1'b0;
    d = sub ? s_rdata : m_rdata;
  endtask

  task automatic read_isr(input bit sub, output logic [7:0] d);
    bus_write(sub, 1'b0, 8'h0B);
    bus_read(sub, 1'b0, d);
    bus_write(sub, 1'b0, 8'h0A);
  endtask

  task automatic setup_unit(input bit sub, input logic [7:0] base,
                            input logic [7:0] link, input logic [7:0] mode);
    bus_write(sub, 1'b0, 8'h11);
    bus_write(sub, 1'b1, base);
    bus_write(sub, 1'b1, link);
    bus_write(sub, 1'b1, mode);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "int_req after reset", {7'd0, m_int}, 8'h00);
    bus_read(1'b0, 1'b0, d);
    chk("R1", "request reg after reset", d, 8'h00);
    bus_read(1'b0, 1'b1, d);
    chk("R1", "mask after reset", d, 8'hFF);
    read_isr(1'b0, d);
    chk("R7", "in-service reg after reset", d, 8'h00);
  endtask

  task automatic t_setup();
    logic [7:0] d;
    bus_write(1'b0, 1'b1, 8'h5A);
    bus_read(1'b0, 1'b1, d);
    chk("R3", "mask readback", d, 8'h5A);
    setup_unit(1'b0, 8'h20, 8'h04, 8'h01);
    bus_read(1'b0, 1'b1, d);
    chk("R2", "mask kept through setup", d, 8'h5A);
    setup_unit(1'b1, 8'h70, 8'h02, 8'h05);
    bus_write(1'b1, 1'b1, 8'h00);
    bus_read(1'b1, 1'b1, d);
    chk("R3", "sub mask readback", d, 8'h00);
  endtask

  task automatic t_mask_all();
    logic [7:0] d;
    bus_write(1'b0, 1'b1, 8'hFF);
    @(negedge clk); m_irq[3] = 1'b1;
    idle(4);
    chk("R13", "int_req with mask FF", {7'd0, m_int}, 8'h00);
    bus_read(1'b0, 1'b0, d);
    chk("R4", "masked edge still latched", d, 8'h08);
    @(negedge clk); m_irq[3] = 1'b0;
    idle(2);
    bus_write(1'b0, 1'b1, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    @(negedge clk); m_irq[4] = 1'b1;
    idle(3);
    chk("R4", "int_req after edge", {7'd0, m_int}, 8'h01);
    bus_read(1'b0, 1'b0, d);
    chk("R4", "request bit 4", d, 8'h10);
    @(negedge clk); m_irq[4] = 1'b0;
    idle(3);
    chk("R4", "int_req after drop", {7'd0, m_int}, 8'h00);
    bus_read(1'b0, 1'b0, d);
    chk("R4", "request cleared on drop", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    @(negedge clk); m_irq[6] = 1'b1; m_irq[3] = 1'b1;
    idle(3);
    pulse_ack();
    chk("R6", "vector valid", {7'd0, m_vv}, 8'h01);
    chk("R5", "winner input 3", m_vec, 8'h23);
    chk("R12", "sub ignores int_ack", {7'd0, s_vv}, 8'h00);
    idle(3);
    chk("R5", "input 6 blocked by level 3", {7'd0, m_int}, 8'h00);
    bus_read(1'b0, 1'b0, d);
    chk("R6", "request 3 cleared", d, 8'h40);
    read_isr(1'b0, d);
    chk("R6", "in-service 3 set", d, 8'h08);
    @(negedge clk); m_irq[1] = 1'b1;
    idle(3);
    chk("R5", "higher level preempts", {7'd0, m_int}, 8'h01);
    pulse_ack();
    chk("R5", "winner input 1", m_vec, 8'h21);
    read_isr(1'b0, d);
    chk("R6", "nested in-service", d, 8'h0A);
    bus_write(1'b0, 1'b0, 8'h61);
    read_isr(1'b0, d);
    chk("R8", "eoi level 1 only", d, 8'h08);
    bus_write(1'b0, 1'b0, 8'h63);
    read_isr(1'b0, d);
    chk("R8", "eoi level 3", d, 8'h00);
    idle(2);
    chk("R5", "input 6 released", {7'd0, m_int}, 8'h01);
    pulse_ack();
    chk("R5", "winner input 6", m_vec, 8'h26);
    bus_write(1'b0, 1'b0, 8'h66);
    read_isr(1'b0, d);
    chk("R8", "eoi level 6", d, 8'h00);
    @(negedge clk); m_irq = '0;
    idle(2);
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    @(negedge clk); m_irq[5] = 1'b1;
    idle(3);
    chk("R4", "int_req for input 5", {7'd0, m_int}, 8'h01);
    @(negedge clk); m_irq[5] = 1'b0;
    pulse_ack();
    chk("R10", "dropped request vector valid", {7'd0, m_vv}, 8'h01);
    chk("R10", "dropped request vector", m_vec, 8'h27);
    read_isr(1'b0, d);
    chk("R10", "no in-service after drop", d, 8'h00);
    @(negedge clk); m_irq[5] = 1'b1;
    idle(3);
    bus_write(1'b0, 1'b1, 8'h20);
    pulse_ack();
    chk("R10", "masked request vector", m_vec, 8'h27);
    read_isr(1'b0, d);
    chk("R10", "no in-service after mask", d, 8'h00);
    @(negedge clk); m_irq[5] = 1'b0;
    bus_write(1'b0, 1'b1, 8'h00);
    idle(2);
  endtask

  task automatic t_auto();
    logic [7:0] d;
    setup_unit(1'b0, 8'h20, 8'h04, 8'h03);
    bus_read(1'b0, 1'b1, d);
    chk("R2", "mask kept through re-setup", d, 8'h00);
    @(negedge clk); m_irq[0] = 1'b1;
    idle(3);
    pulse_ack();
    chk("R9", "auto-mode vector", m_vec, 8'h20);
    read_isr(1'b0, d);
    chk("R9", "auto-mode in-service empty", d, 8'h00);
    @(negedge clk); m_irq[0] = 1'b0;
    setup_unit(1'b0, 8'h20, 8'h04, 8'h01);
  endtask

  task automatic t_cascade();
    logic [7:0] d;
    @(negedge clk); s_irq[5] = 1'b1;
    idle(6);
    chk("R11", "master request via sub", {7'd0, m_int}, 8'h01);
    pulse_ack();
    chk("R11", "master gives no vector", {7'd0, m_vv}, 8'h00);
    chk("R11", "cascade strobe", {7'd0, m_cstb}, 8'h01);
    chk("R11", "cascade number", {5'd0, m_cid}, 8'h02);
    chk("R12", "sub waits for strobe", {7'd0, s_vv}, 8'h00);
    @(negedge clk);
    chk("R12", "sub vector valid", {7'd0, s_vv}, 8'h01);
    chk("R12", "sub vector", s_vec, 8'h75);
    read_isr(1'b1, d);
    chk("R12", "sub in-service 5", d, 8'h20);
    read_isr(1'b0, d);
    chk("R11", "master in-service 2", d, 8'h04);
    bus_write(1'b1, 1'b0, 8'h65);
    bus_write(1'b0, 1'b0, 8'h62);
    read_isr(1'b1, d);
    chk("R8", "sub retired", d, 8'h00);
    read_isr(1'b0, d);
    chk("R8", "master retired", d, 8'h00);
    @(negedge clk); s_irq = '0;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_setup();
    t_mask_all();
    t_edge();
    t_priority();
    t_spurious();
    t_auto();
    t_cascade();
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule